// File: doc/BRIEF.md
# Even-Ratio Programmable Clock Divider

This block derives a slower clock from its input clock without creating a new clock net. It keeps a period counter running on the input clock. From that counter it drives a divided level with a 50% duty cycle and a one-cycle tick that marks the last input cycle of every output period. Downstream logic either uses the tick as a clock enable or treats the level as the divided waveform. A select code sets the ratio. In the default mapping, code 0 passes the rate through (every input cycle is a full output period) and a nonzero code n divides by 2n. A parameter selects a second mapping in which the code is a power-of-two exponent.

The same module is instantiated at several widths. A 6-bit select serves the main system clock, with ratios from 1 to 126. A 3-bit select serves a low-speed peripheral clock, with ratios 1, 2, 4, up to 14. A 2-bit power-of-two variant gives ratios 1, 2, 4 and 8, and its reset code is a parameter. Software may change the code at any time. The block samples the code only on the input cycle that closes an output period, so every output phase lasts a whole number of input cycles and no runt pulse occurs.

Top module: `clk_ratio_div`

## Requirements
- R1: While reset is asserted, and in the first input cycle after its release, the state is loaded from the parameter RESET_CODE. With the default code 2 the level output is high and the tick is low, and the first output period after release lasts 4 input cycles.
- R2: In the even mapping (MAP=0), a nonzero code n gives an output period of 2n input cycles. The tick is high only on the last input cycle of each period.
- R3: In the even mapping, when dividing by 2n the level output is high for the first n input cycles of each period and low for the last n. It rises only in the cycle after a tick.
- R4: Code 0 selects pass-through: the tick and the level output are both high on every input cycle.
- R5: A code change in the middle of a period has no effect on that period. The new ratio applies from the input cycle after the next tick.
- R6: A 3-bit even-mapped instance gives periods of 2, 4, 6, 8, 10, 12 and 14 input cycles for codes 1 to 7.
- R7: In the power-of-two mapping (MAP=1) with a 2-bit select, codes 0, 1, 2 and 3 give periods of 1, 2, 4 and 8 input cycles, and reset loads the parameter RESET_CODE.
- R8: The largest 6-bit code, 63, gives a period of 126 input cycles with 63 high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | SEL_W | Divide select code, sampled at output period boundaries |
| div_lvl_o | output | 1 | Divided level, high in the first half of each output period |
| div_tick_o | output | 1 | One-cycle tick on the last input cycle of each output period |

## Verification
A wrong counter or a wrong latched ratio changes the spacing between ticks. The error appears at the ports no later than the end of the first faulty period, which is at most 126 input cycles. A ratio latched at the wrong moment shows up as one period whose length matches neither the old code nor the new one, or as a duty split that differs from half. A decode error for a single code shows up only when that code is applied, so every code of the narrow instances is applied and the wide instance is swept at its extremes and at random.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int MAP_EVEN = 0;
    localparam int MAP_POW2 = 1;

    // width of the stored half-period count for a given select width and mapping
    function automatic int half_width(input int sel_w, input int map);
        if (map == MAP_POW2)
            return (1 << sel_w) - 1;
        return sel_w;
    endfunction

    // half-period length for a code; 0 means pass-through
    function automatic int decode_half(input int map, input int code);
        if (code == 0)
            return 0;
        if (map == MAP_POW2)
            return 1 << (code - 1);
        return code;
    endfunction

endpackage

// File: rtl/cdiv_decode.sv
module cdiv_decode #(
    parameter int SEL_W  = 6,
    parameter int MAP    = 0,
    parameter int HALF_W = 6
) (
    input  logic [SEL_W-1:0]  code_i,
    output logic [HALF_W-1:0] half_o,
    output logic              bypass_o
);

    localparam int NCODES = 1 << SEL_W;

    assign bypass_o = (code_i == '0);

    generate
        if (MAP == clkdiv_pkg::MAP_POW2) begin : g_pow2
            always_comb begin
                half_o = '0;
                for (int i = 1; i < NCODES; i++) begin
                    if (code_i == SEL_W'(i))
                        half_o = HALF_W'(1) << (i - 1);
                end
            end
        end else begin : g_even
            always_comb begin
                half_o = HALF_W'(code_i);
            end
        end
    endgenerate

endmodule

// File: rtl/cdiv_period.sv
module cdiv_period #(
    parameter int                 HALF_W     = 6,
    parameter logic [HALF_W-1:0]  RST_HALF   = '0,
    parameter logic               RST_BYPASS = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [HALF_W-1:0] nxt_half_i,
    input  logic              nxt_bypass_i,
    output logic              tick_o,
    output logic              lvl_o,
    output logic [HALF_W-1:0] cur_half_o
);

    localparam int CNT_W = HALF_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [HALF_W-1:0] half;
        logic              bypass;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W-1:0] last_idx;
    logic             at_end;

    always_comb begin
        last_idx = {st_q.half, 1'b0} - CNT_W'(1);
        at_end   = st_q.bypass || (st_q.cnt == last_idx);
        st_d     = st_q;
        if (at_end) begin
            st_d.cnt    = '0;
            st_d.half   = nxt_half_i;
            st_d.bypass = nxt_bypass_i;
        end else begin
            st_d.cnt    = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt    <= '0;
            st_q.half   <= RST_HALF;
            st_q.bypass <= RST_BYPASS;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o     = at_end;
    assign lvl_o      = st_q.bypass || (st_q.cnt < {1'b0, st_q.half});
    assign cur_half_o = st_q.half;

endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
    parameter int SEL_W      = 6,
    parameter int MAP        = 0,
    parameter int RESET_CODE = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    output logic             div_lvl_o,
    output logic             div_tick_o
);

    localparam int                HALF_W     = clkdiv_pkg::half_width(SEL_W, MAP);
    localparam logic [HALF_W-1:0] RST_HALF   = HALF_W'(clkdiv_pkg::decode_half(MAP, RESET_CODE));
    localparam logic              RST_BYPASS = (RESET_CODE == 0);

    logic [HALF_W-1:0] nxt_half;
    logic              nxt_bypass;
    logic [HALF_W-1:0] cur_half;

    cdiv_decode #(
        .SEL_W  (SEL_W),
        .MAP    (MAP),
        .HALF_W (HALF_W)
    ) u_decode (
        .code_i   (sel_i),
        .half_o   (nxt_half),
        .bypass_o (nxt_bypass)
    );

    cdiv_period #(
        .HALF_W     (HALF_W),
        .RST_HALF   (RST_HALF),
        .RST_BYPASS (RST_BYPASS)
    ) u_period (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .nxt_half_i   (nxt_half),
        .nxt_bypass_i (nxt_bypass),
        .tick_o       (div_tick_o),
        .lvl_o        (div_lvl_o),
        .cur_half_o   (cur_half)
    );

endmodule

// File: rtl/clk_ratio_div_chk.sv
module clk_ratio_div_chk #(
    parameter int SEL_W      = 6,
    parameter int HALF_W     = 6,
    parameter int RESET_CODE = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [SEL_W-1:0]  sel_i,
    input logic              div_lvl_o,
    input logic              div_tick_o,
    input logic [HALF_W-1:0] cur_half
);

    logic [15:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            run_q <= '0;
        else if (div_tick_o)
            run_q <= '0;
        else
            run_q <= run_q + 16'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (div_lvl_o && (div_tick_o == (RESET_CODE == 0))));

    assert_period_even_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_tick_o |-> (run_q[0] || (run_q == 16'd0)));

    assert_rise_after_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(div_lvl_o) |-> $past(div_tick_o));

    assert_passthrough_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == '0 && div_tick_o) |=> (div_tick_o && div_lvl_o));

    assert_ratio_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !div_tick_o |=> $stable(cur_half));

endmodule

bind clk_ratio_div clk_ratio_div_chk #(
    .SEL_W      (SEL_W),
    .HALF_W     (HALF_W),
    .RESET_CODE (RESET_CODE)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .div_lvl_o  (div_lvl_o),
    .div_tick_o (div_tick_o),
    .cur_half   (cur_half)
);

// File: tb/clk_ratio_div_tb.sv
module clk_ratio_div_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] sel6 = 6'd2;
    logic [2:0] sel3 = 3'd2;
    logic [1:0] sel2 = 2'd3;
    logic [2:0] lvl, tck;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    clk_ratio_div #(.SEL_W(6), .MAP(0), .RESET_CODE(2)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel6), .div_lvl_o(lvl[0]), .div_tick_o(tck[0]));
    clk_ratio_div #(.SEL_W(3), .MAP(0), .RESET_CODE(2)) u_lsp (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel3), .div_lvl_o(lvl[1]), .div_tick_o(tck[1]));
    clk_ratio_div #(.SEL_W(2), .MAP(1), .RESET_CODE(3)) u_p2 (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel2), .div_lvl_o(lvl[2]), .div_tick_o(tck[2]));

    function automatic int exp_len(input int pow2, input int code);
        if (code == 0) return 1;
        if (pow2 != 0) return 1 << code;
        return 2 * code;
    endfunction

    function automatic int exp_hi(input int len);
        return (len == 1) ? 1 : len / 2;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sync_tick(input int k);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!tck[k] && guard < 400);
    endtask

    task automatic count_to_tick(input int k, output int len, output int hi);
        len = 0;
        hi  = 0;
        do begin
            @(negedge clk);
            len++;
            if (lvl[k]) hi++;
        end while (!tck[k] && len < 400);
    endtask

    task automatic measure(input int k, output int len, output int hi);
        sync_tick(k);
        count_to_tick(k, len, hi);
    endtask

    task automatic first_period(input int k, output int len, output int hi);
        len = 1;
        hi  = lvl[k] ? 1 : 0;
        while (!tck[k] && len < 400) begin
            @(negedge clk);
            len++;
            if (lvl[k]) hi++;
        end
    endtask

    task automatic try_dut(input int code, input string req);
        int l, h;
        sel6 = 6'(code);
        measure(0, l, h);
        check({req, " period"}, l, exp_len(0, code));
        check({req, " high"},   h, exp_hi(exp_len(0, code)));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int l0, h0, l1, h1, l2, h2;
        void'($urandom(32'h5eed_c10c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state right after reset release
        check("R1 lvl main", int'(lvl[0]), 1);
        check("R1 tick main", int'(tck[0]), 0);
        check("R1 lvl lsp", int'(lvl[1]), 1);
        check("R1 tick lsp", int'(tck[1]), 0);
        fork
            first_period(0, l0, h0);
            first_period(1, l1, h1);
            first_period(2, l2, h2);
        join
        check("R1 first period main", l0, 4);
        check("R1 first high main", h0, 2);
        check("R1 first period lsp", l1, 4);
        check("R7 reset code period pow2", l2, 8);
        check("R7 reset code high pow2", h2, 4);

        // R2/R3 directed and R8 extreme
        try_dut(1, "R2 code1");
        try_dut(5, "R3 code5");
        try_dut(63, "R8 code63");

        // R2 random codes
        for (int i = 0; i < 12; i++) begin
            int c = 1 + int'($urandom_range(62));
            try_dut(c, "R2 random");
        end

        // R4 pass-through
        sel6 = 6'd0;
        sync_tick(0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R4 tick", int'(tck[0]), 1);
            check("R4 lvl",  int'(lvl[0]), 1);
        end
        try_dut(3, "R4 leave bypass");

        // R5 mid-period change
        begin
            int l, h;
            sel6 = 6'd4;
            measure(0, l, h);
            check("R5 setup", l, 8);
            @(negedge clk);
            sel6 = 6'd2;
            count_to_tick(0, l, h);
            check("R5 old ratio kept", l + 1, 8);
            count_to_tick(0, l, h);
            check("R5 new ratio", l, 4);
            check("R5 new high", h, 2);
        end

        // R6 low-speed instance, every code
        for (int c = 0; c < 8; c++) begin
            int l, h;
            sel3 = 3'(c);
            measure(1, l, h);
            check("R6 period", l, exp_len(0, c));
            check("R6 high", h, exp_hi(exp_len(0, c)));
        end

        // R7 power-of-two instance, every code
        for (int c = 0; c < 4; c++) begin
            int l, h;
            sel2 = 2'(c);
            measure(2, l, h);
            check("R7 period", l, exp_len(1, c));
            check("R7 high", h, exp_hi(exp_len(1, c)));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule